// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block decides which of three operating modes a small LED driver die is in: powered down (OFF), low-power retention (Standby) or fully active (Normal). A fourth code marks a thermal shutdown. The inputs it uses are an external regulator enable pin, two retention bits held in the block, an active-low reset pin, a thermal shutdown flag and a logic-supply-good flag. From these it drives the enables of the two on-die regulators and a flag that tells the serial decoder whether traffic may be accepted. It also raises a register-reset request toward the rest of the register file. The analog regulators, bandgap and temperature sensor are outside the block and appear only as the input flags.

The two retention bits are written through a small write port that the serial decoder drives. A write takes effect only while the accept flag is high. While the enable pin is high the die is always in Normal mode. When the pin drops, the retention bits choose the next mode. Standby keeps only the second regulator alive. It ignores serial traffic and cannot fall to OFF, so it is left only when the pin rises again. A startup window, counted in cycles of the free-running internal clock, has to elapse in Normal mode before serial traffic is accepted.

Top module: `pwr_mode_seq`

## Requirements
- R1: After the power-on reset `mode_o` reads OFF (mode codes: 0 OFF, 1 Standby, 2 Normal, 3 thermal shutdown). In that state both regulator enables, `accept_o`, `therm_stat_o` and `irq_o` are 0, and `rst_req_o` is 1.
- R2: Three clock cycles after `ldo_en_i` rises, with no thermal flag, the mode is Normal and both regulator enables are 1, whatever the retention bits hold.
- R3: Three cycles after `ldo_en_i` falls in Normal mode, the retention bits choose the mode. Second-regulator bit 0 gives OFF with both enables 0. Second bit 1 with first-regulator bit 0 gives Standby, with only `reg2_en_o` at 1. Both bits 1 keep Normal mode with both enables on.
- R4: With no reset active, `accept_o` goes high exactly DELAY cycles after the mode becomes Normal on a pin rise, that is 3+DELAY cycles after the rise. DELAY = CLK_KHZ*DELAY_US/1000. `accept_o` is never high outside Normal mode.
- R5: A write (`wr_en_i` with `wr_keep1_i` as the first-regulator bit and `wr_keep2_i` as the second-regulator bit) is stored only while `accept_o` is 1. At any other time it has no effect.
- R6: In Standby with `ldo_en_i` low, the mode stays Standby whatever arrives on the write port or the reset pin. A rise of `ldo_en_i` moves it to Normal three cycles later.
- R7: Three cycles after `rst_pin_ni` goes low outside OFF mode, `rst_req_o` is 1 and `accept_o` is 0. Both retention bits are then loaded with 1.
- R8: Whenever the second regulator is off (OFF or thermal shutdown), both retention bits are cleared. The reset pin does not load the defaults in OFF mode, so a Normal entry from OFF followed by a pin fall returns to OFF.
- R9: Three cycles after `therm_i` rises, the mode is thermal shutdown. Both enables and `accept_o` are then 0, and `rst_req_o` and `therm_stat_o` are 1. `irq_o` is high for exactly that one cycle.
- R10: Three cycles after `therm_i` falls, the mode is Normal with both regulators on. The logic is held in reset (`rst_req_o` 1, `accept_o` 0) until 4+DELAY cycles after the fall, when both are released.
- R11: While `supply_ok_i` is 0, `accept_o` is 0. It returns on the next cycle after the flag comes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running internal clock |
| arst_ni | input | 1 | Power-on reset, asynchronous assert, active low |
| ldo_en_i | input | 1 | External regulator enable pin, asynchronous |
| rst_pin_ni | input | 1 | Reset pin, active low, asynchronous |
| therm_i | input | 1 | Thermal shutdown flag from the sensor |
| supply_ok_i | input | 1 | Logic supply good flag |
| wr_en_i | input | 1 | Retention-bit write strobe from the serial decoder |
| wr_keep1_i | input | 1 | Write data for the first-regulator retention bit |
| wr_keep2_i | input | 1 | Write data for the second-regulator retention bit |
| mode_o | output | 2 | Current mode code |
| reg1_en_o | output | 1 | First regulator enable |
| reg2_en_o | output | 1 | Second regulator enable |
| accept_o | output | 1 | Serial traffic may be accepted |
| rst_req_o | output | 1 | Register-reset request to the register file |
| therm_stat_o | output | 1 | Thermal shutdown status |
| irq_o | output | 1 | One-cycle interrupt on thermal shutdown entry |

## Verification
Each asynchronous pin passes through a two-stage synchroniser before it reaches the mode register. A change on `ldo_en_i`, `rst_pin_ni` or `therm_i` therefore shows on the mode, the enables, `rst_req_o`, `therm_stat_o` and `irq_o` three edges later. `accept_o` follows 3+DELAY edges after a pin rise and 4+DELAY edges after a thermal recovery, and it drops one sample after `supply_ok_i` falls. The driver stamps every expected item with the cycle in which it is due. The monitor compares it at the falling edge of exactly that cycle, and the check just before each `accept_o` rise pins the window to the cycle. Requirements that say a write or a reset is ignored are observed by dropping the enable pin afterwards and reading the mode the retention bits select.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_NORM  = 2'd2,
    MODE_THERM = 2'd3
  } pwr_mode_e;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= RST_VAL;
        else         stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int DELAY = 6000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_normal_i,
  input  logic count_en_i,
  output logic done_o
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = (cnt_q == CW'(DELAY));

  always_comb begin
    cnt_d = cnt_q;
    if (!in_normal_i)                cnt_d = '0;
    else if (count_en_i && !done_o)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R4: once the window has elapsed it stays elapsed while Normal persists
  assert_window_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && in_normal_i) |=> done_o);
  // R4: leaving Normal restarts the window
  assert_window_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_normal_i |=> !done_o);
endmodule

// File: rtl/pwr_seq_keep.sv
module pwr_seq_keep
  import pwr_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pwr_mode_e mode_i,
  input  logic      force_dflt_i,
  input  logic      accept_i,
  input  logic      wr_en_i,
  input  logic      wr_keep1_i,
  input  logic      wr_keep2_i,
  output logic      keep1_o,
  output logic      keep2_o
);
  logic keep1_q, keep2_q, keep1_d, keep2_d;
  logic reg2_off, wr_take;

  assign reg2_off = (mode_i == MODE_OFF) || (mode_i == MODE_THERM);
  assign wr_take  = wr_en_i && accept_i;

  always_comb begin
    keep1_d = keep1_q;
    keep2_d = keep2_q;
    if (reg2_off) begin
      keep1_d = 1'b0;
      keep2_d = 1'b0;
    end else if (force_dflt_i) begin
      keep1_d = 1'b1;
      keep2_d = 1'b1;
    end else if (wr_take) begin
      keep1_d = wr_keep1_i;
      keep2_d = wr_keep2_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep1_q <= 1'b0;
      keep2_q <= 1'b0;
    end else begin
      keep1_q <= keep1_d;
      keep2_q <= keep2_d;
    end
  end

  assign keep1_o = keep1_q;
  assign keep2_o = keep2_q;

  // R8: second regulator off wipes both retention bits
  assert_cleared_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |=> (!keep1_o && !keep2_o));
  // R5: without accept, reset or power loss the bits hold
  assert_write_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept_i && !force_dflt_i && !reg2_off) |=> ($stable(keep1_o) && $stable(keep2_o)));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ldo_s_i,
  input  logic      rst_pin_s_ni,
  input  logic      therm_s_i,
  input  logic      keep1_i,
  input  logic      keep2_i,
  input  logic      done_i,
  output pwr_mode_e mode_o,
  output logic      hold_o,
  output logic      rst_req_o,
  output logic      irq_o
);
  pwr_mode_e mode_q, mode_d;
  logic      hold_q, hold_d;
  logic      rreq_q, rreq_d;
  logic      irq_q, irq_d;

  always_comb begin
    mode_d = mode_q;
    if (therm_s_i) begin
      mode_d = MODE_THERM;
    end else begin
      unique case (mode_q)
        MODE_THERM: mode_d = MODE_NORM;
        MODE_OFF:   if (ldo_s_i) mode_d = MODE_NORM;
        MODE_STBY:  if (ldo_s_i) mode_d = MODE_NORM;
        MODE_NORM: begin
          if (!ldo_s_i && !rreq_q) begin
            if (!keep2_i)      mode_d = MODE_OFF;
            else if (!keep1_i) mode_d = MODE_STBY;
          end
        end
        default:    mode_d = MODE_OFF;
      endcase
    end
  end

  always_comb begin
    hold_d = (mode_d == MODE_NORM) &&
             ((mode_q == MODE_THERM) || (hold_q && !done_i));
    rreq_d = !rst_pin_s_ni || (mode_d == MODE_OFF) ||
             (mode_d == MODE_THERM) || hold_d;
    irq_d  = (mode_d == MODE_THERM) && (mode_q != MODE_THERM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      hold_q <= 1'b0;
      rreq_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      hold_q <= hold_d;
      rreq_q <= rreq_d;
      irq_q  <= irq_d;
    end
  end

  assign mode_o    = mode_q;
  assign hold_o    = hold_q;
  assign rst_req_o = rreq_q;
  assign irq_o     = irq_q;

  // R6: Standby never drops straight to OFF
  assert_stby_not_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STBY) |=> (mode_q != MODE_OFF));
  // R6: Standby persists while the pin is low and no thermal event
  assert_stby_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STBY && !ldo_s_i && !therm_s_i) |=> (mode_q == MODE_STBY));
  // R9: interrupt lasts a single cycle
  assert_irq_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  // R10: recovery from thermal shutdown keeps the logic in reset
  assert_recovery_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_THERM && !therm_s_i) |=> (rreq_q && mode_q == MODE_NORM));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int CLK_KHZ     = 1200,
  parameter int DELAY_US    = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       arst_ni,
  input  logic       ldo_en_i,
  input  logic       rst_pin_ni,
  input  logic       therm_i,
  input  logic       supply_ok_i,
  input  logic       wr_en_i,
  input  logic       wr_keep1_i,
  input  logic       wr_keep2_i,
  output logic [1:0] mode_o,
  output logic       reg1_en_o,
  output logic       reg2_en_o,
  output logic       accept_o,
  output logic       rst_req_o,
  output logic       therm_stat_o,
  output logic       irq_o
);
  localparam int DELAY = CLK_KHZ * DELAY_US / 1000;
  localparam int NPIN  = 3;

  // power-on reset: asynchronous assert, synchronous release
  logic [1:0] por_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) por_q <= 2'b00;
    else          por_q <= {por_q[0], 1'b1};
  end
  assign rst_n = por_q[1];

  // pin synchronisers: {therm, reset pin, enable pin}
  logic [NPIN-1:0] pin_raw, pin_s;
  assign pin_raw = {therm_i, rst_pin_ni, ldo_en_i};

  pwr_seq_sync #(
    .WIDTH  (NPIN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b000)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  logic ldo_s, rst_pin_s_n, therm_s;
  assign ldo_s       = pin_s[0];
  assign rst_pin_s_n = pin_s[1];
  assign therm_s     = pin_s[2];

  pwr_mode_e mode;
  logic      hold, rreq, irq, done, keep1, keep2, accept;

  pwr_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .ldo_s_i     (ldo_s),
    .rst_pin_s_ni(rst_pin_s_n),
    .therm_s_i   (therm_s),
    .keep1_i     (keep1),
    .keep2_i     (keep2),
    .done_i      (done),
    .mode_o      (mode),
    .hold_o      (hold),
    .rst_req_o   (rreq),
    .irq_o       (irq)
  );

  pwr_seq_timer #(.DELAY(DELAY)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .in_normal_i(mode == MODE_NORM),
    .count_en_i (ldo_s || hold),
    .done_o     (done)
  );

  assign accept = (mode == MODE_NORM) && done && !rreq && supply_ok_i;

  pwr_seq_keep u_keep (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .force_dflt_i(rreq),
    .accept_i    (accept),
    .wr_en_i     (wr_en_i),
    .wr_keep1_i  (wr_keep1_i),
    .wr_keep2_i  (wr_keep2_i),
    .keep1_o     (keep1),
    .keep2_o     (keep2)
  );

  assign mode_o       = mode;
  assign reg1_en_o    = (mode == MODE_NORM);
  assign reg2_en_o    = (mode == MODE_NORM) || (mode == MODE_STBY);
  assign accept_o     = accept;
  assign rst_req_o    = rreq;
  assign therm_stat_o = (mode == MODE_THERM);
  assign irq_o        = irq;

  // R2: a synchronised pin rise always lands in Normal
  assert_pin_wakes_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($rose(ldo_s) && !therm_s) |=> (mode == MODE_NORM));
  // R4: traffic only with both regulators up
  assert_accept_powered_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    accept_o |-> (reg1_en_o && reg2_en_o));
  // R9: thermal entry raises the interrupt with the status
  assert_irq_on_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(therm_stat_o) |-> irq_o);
  // R7: a synchronised reset blocks traffic on the next cycle
  assert_reset_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rst_pin_s_n |=> !accept_o);
endmodule

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;
  localparam int CLK_KHZ  = 1200;
  localparam int DELAY_US = 20;
  localparam int D        = CLK_KHZ * DELAY_US / 1000;

  localparam logic [1:0] M_OFF = 2'd0, M_STBY = 2'd1, M_NORM = 2'd2, M_THERM = 2'd3;

  logic clk = 1'b0;
  logic arst_n, ldo_en, rst_pin_n, therm, supply_ok, wr_en, wr_k1, wr_k2;
  logic [1:0] mode;
  logic reg1_en, reg2_en, accept, rst_req, tstat, irq;

  always #4 clk = ~clk;

  pwr_mode_seq #(.CLK_KHZ(CLK_KHZ), .DELAY_US(DELAY_US)) dut (
    .clk_i(clk), .arst_ni(arst_n), .ldo_en_i(ldo_en), .rst_pin_ni(rst_pin_n),
    .therm_i(therm), .supply_ok_i(supply_ok), .wr_en_i(wr_en),
    .wr_keep1_i(wr_k1), .wr_keep2_i(wr_k2), .mode_o(mode), .reg1_en_o(reg1_en),
    .reg2_en_o(reg2_en), .accept_o(accept), .rst_req_o(rst_req),
    .therm_stat_o(tstat), .irq_o(irq)
  );

  typedef struct {
    int         due;
    logic [7:0] vec;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int dly, logic [1:0] m, logic r1, logic r2, logic acc,
                           logic rr, logic st, logic iq, string tag);
    exp_t e;
    e.due = cyc + dly;
    e.vec = {m, r1, r2, acc, rr, st, iq};
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares each expected item in the cycle it is due
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due <= cyc) begin
      logic [7:0] act;
      act = {mode, reg1_en, reg2_en, accept, rst_req, tstat, irq};
      n_chk++;
      if (sb[0].due < cyc) begin
        n_fail++;
        $display("FAIL %s: item missed, due %0d now %0d", sb[0].tag, sb[0].due, cyc);
      end else if (act !== sb[0].vec) begin
        n_fail++;
        $display("FAIL %s: cycle %0d actual %b expected %b (mode,r1,r2,acc,rreq,stat,irq)",
                 sb[0].tag, cyc, act, sb[0].vec);
      end
      void'(sb.pop_front());
    end
  end

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rst(int n);
    @(negedge clk) rst_pin_n = 1'b0;
    idle(n);
    rst_pin_n = 1'b1;
  endtask

  task automatic write_keep(logic k1, logic k2);
    @(negedge clk);
    wr_en = 1'b1; wr_k1 = k1; wr_k2 = k2;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    arst_n = 1'b0; ldo_en = 1'b0; rst_pin_n = 1'b1; therm = 1'b0;
    supply_ok = 1'b1; wr_en = 1'b0; wr_k1 = 1'b0; wr_k2 = 1'b0;
    idle(3);
    arst_n = 1'b1;
    idle(5);
    // R1 reset state
    expect_at(1, M_OFF, 0, 0, 0, 1, 0, 0, "R1");
    drain();

    // R2 / R4: pin rise, then the accept window
    @(negedge clk) ldo_en = 1'b1;
    expect_at(3, M_NORM, 1, 1, 0, 0, 0, 0, "R2");
    expect_at(2 + D, M_NORM, 1, 1, 0, 0, 0, 0, "R4");
    expect_at(3 + D, M_NORM, 1, 1, 1, 0, 0, 0, "R4");
    drain();

    // R7: reset pin in Normal loads defaults and blocks traffic
    @(negedge clk) rst_pin_n = 1'b0;
    expect_at(3, M_NORM, 1, 1, 0, 1, 0, 0, "R7");
    drain();
    idle(3);
    @(negedge clk) rst_pin_n = 1'b1;
    expect_at(3, M_NORM, 1, 1, 1, 0, 0, 0, "R7");
    drain();

    // R3: both retention bits at 1 keep Normal after pin fall
    @(negedge clk) ldo_en = 1'b0;
    expect_at(3, M_NORM, 1, 1, 1, 0, 0, 0, "R3");
    expect_at(8, M_NORM, 1, 1, 1, 0, 0, 0, "R3");
    drain();

    // R3: only second bit set gives Standby
    @(negedge clk) ldo_en = 1'b1;
    write_keep(1'b0, 1'b1);
    idle(3);
    @(negedge clk) ldo_en = 1'b0;
    expect_at(3, M_STBY, 0, 1, 0, 0, 0, 0, "R3");
    drain();

    // R6: writes and reset cannot move Standby
    write_keep(1'b0, 1'b0);
    pulse_rst(4);
    expect_at(3, M_STBY, 0, 1, 0, 0, 0, 0, "R6");
    expect_at(10, M_STBY, 0, 1, 0, 0, 0, 0, "R6");
    drain();
    @(negedge clk) ldo_en = 1'b1;
    expect_at(3, M_NORM, 1, 1, 0, 0, 0, 0, "R6");
    expect_at(3 + D, M_NORM, 1, 1, 1, 0, 0, 0, "R4");
    drain();

    // R5: accepted write of 0,0 then pin fall gives OFF
    write_keep(1'b0, 1'b0);
    idle(2);
    @(negedge clk) ldo_en = 1'b0;
    expect_at(3, M_OFF, 0, 0, 0, 1, 0, 0, "R5");
    drain();

    // R8: reset in OFF loads nothing; next Normal falls back to OFF
    pulse_rst(4);
    expect_at(3, M_OFF, 0, 0, 0, 1, 0, 0, "R8");
    drain();
    @(negedge clk) ldo_en = 1'b1;
    expect_at(3, M_NORM, 1, 1, 0, 0, 0, 0, "R8");
    drain();
    idle(4);
    @(negedge clk) ldo_en = 1'b0;
    expect_at(3, M_OFF, 0, 0, 0, 1, 0, 0, "R8");
    drain();

    // R5: write before the window elapses is ignored
    @(negedge clk) ldo_en = 1'b1;
    expect_at(3, M_NORM, 1, 1, 0, 0, 0, 0, "R5");
    drain();
    write_keep(1'b1, 1'b1);
    ldo_en = 1'b0;
    expect_at(3, M_OFF, 0, 0, 0, 1, 0, 0, "R5");
    drain();

    // R11: supply flag gates accept
    @(negedge clk) ldo_en = 1'b1;
    expect_at(3 + D, M_NORM, 1, 1, 1, 0, 0, 0, "R4");
    drain();
    @(negedge clk) supply_ok = 1'b0;
    expect_at(1, M_NORM, 1, 1, 0, 0, 0, 0, "R11");
    drain();
    @(negedge clk) supply_ok = 1'b1;
    expect_at(1, M_NORM, 1, 1, 1, 0, 0, 0, "R11");
    drain();

    // R9: thermal shutdown entry
    @(negedge clk) therm = 1'b1;
    expect_at(3, M_THERM, 0, 0, 0, 1, 1, 1, "R9");
    expect_at(4, M_THERM, 0, 0, 0, 1, 1, 0, "R9");
    drain();

    // R10: recovery with logic held in reset for the window
    @(negedge clk) therm = 1'b0;
    expect_at(3, M_NORM, 1, 1, 0, 1, 0, 0, "R10");
    expect_at(3 + D, M_NORM, 1, 1, 0, 1, 0, 0, "R10");
    expect_at(4 + D, M_NORM, 1, 1, 1, 0, 0, 0, "R10");
    drain();

    idle(2);
    finish_run();
  end
endmodule